// File: doc/BRIEF.md
# Banked Memory Map Address Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories of a small handheld-style system. It looks at every CPU address, works out which memory region the address falls in, and steers the byte read or byte write to that region: fixed and switchable cartridge ROM, video RAM, the external cartridge window (clock registers or battery-backed SRAM), fixed and switchable work RAM with their mirror, sprite attribute RAM, an unusable hole, the I/O page, high RAM and the interrupt-enable register.

The large memories stay outside and are reached through simple address, write-strobe and read-data ports. The block itself holds the work-RAM bank register, the sprite attribute RAM, high RAM, the clock registers, the interrupt-enable byte and two sticky flags. Sprite RAM is only reachable while the video unit reports mode 0 or 1, and any write to the ROM range is passed to the cartridge mapper instead of a memory. Read data is combinational from the address and the current bank state; writes commit on the rising clock edge while the write strobe is high.

Top module: `banked_mem_decoder`

## Requirements
- R1: A read in 0x0000-0x3FFF drives `rom_addr` = {0, addr[13:0]}, a read in 0x4000-0x7FFF drives `rom_addr` = {`rom_bank_sel`, addr[13:0]}, and in both cases `cpu_rdata` equals `rom_rdata`.
- R2: A write in 0x0000-0x7FFF raises `mapper_we` with `mapper_addr` = addr[14:0] and data on `mem_wdata`, and raises no memory write strobe.
- R3: Addresses 0x8000-0x9FFF reach video RAM with `vram_addr` = addr[12:0]; reads return `vram_rdata` and writes raise `vram_we`.
- R4: Addresses 0xC000-0xCFFF drive `wram_addr` = {0, addr[11:0]}; addresses 0xD000-0xDFFF drive `wram_addr` = {effective bank, addr[11:0]}; writes in either raise `wram_we`.
- R5: The bank register sits at I/O address 0xFF70 and keeps only bits [2:0] of a written byte; a stored 0 selects bank 1, reset stores 0, and a read of 0xFF70 returns {5'b11111, stored bits}.
- R6: 0xE000-0xEFFF behaves as 0xC000-0xCFFF and 0xF000-0xFDFF behaves as the switchable work-RAM bank at the same low 12 address bits.
- R7: Sprite RAM at 0xFE00-0xFE9F is read and written only while `video_mode` is 0 or 1; with mode 2 or 3 reads return 0xFF and writes leave the contents unchanged.
- R8: Reads in 0xFEA0-0xFEFF return 0xFF, writes there change no storage and raise no write strobe, and a write there sets the sticky `hole_err` flag.
- R9: In 0xA000-0xBFFF, when `clk_regs_on` is 1 the access goes to clock register `clk_reg_idx` (an index at or above the register count reads 0xFF, writes dropped); otherwise when `sram_on` is 1 it goes to SRAM with `sram_addr` = addr[12:0]; otherwise reads return 0xFF and nothing is written.
- R10: Any write in 0xA000-0xBFFF sets the sticky `sram_dirty` flag, which only reset clears.
- R11: 0xFF00-0xFF7F other than 0xFF70 reaches the I/O port with `io_addr` = addr[6:0]; 0xFF80-0xFFFE is internal high RAM, cleared by reset.
- R12: 0xFFFF is the 8-bit interrupt-enable register, cleared by reset, readable through `cpu_rdata` and always visible on `irq_enable`.
- R13: Read data follows the address in the same cycle; a write becomes visible only after the rising edge on which `cpu_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| video_mode | input | 2 | Current video mode 0-3 |
| clk_regs_on | input | 1 | External window maps clock registers |
| sram_on | input | 1 | External window maps SRAM |
| clk_reg_idx | input | CLK_IDX_W (3) | Selected clock register |
| rom_bank_sel | input | ROM_BANK_W (8) | Switchable ROM bank from the mapper |
| rom_addr | output | ROM_BANK_W+14 (22) | ROM byte address |
| rom_rdata | input | 8 | ROM read data |
| mapper_we | output | 1 | Mapper control write strobe |
| mapper_addr | output | 15 | Mapper control write address |
| vram_addr | output | 13 | Video RAM address |
| vram_we | output | 1 | Video RAM write strobe |
| vram_rdata | input | 8 | Video RAM read data |
| sram_addr | output | 13 | External SRAM address |
| sram_we | output | 1 | External SRAM write strobe |
| sram_rdata | input | 8 | External SRAM read data |
| wram_addr | output | WRAM_BANK_W+12 (15) | Work RAM address |
| wram_we | output | 1 | Work RAM write strobe |
| wram_rdata | input | 8 | Work RAM read data |
| io_addr | output | 7 | I/O register offset |
| io_we | output | 1 | I/O write strobe |
| io_rdata | input | 8 | I/O read data |
| mem_wdata | output | 8 | Shared write data to all external targets |
| sram_dirty | output | 1 | Sticky: external window was written |
| hole_err | output | 1 | Sticky: unusable range was written |
| irq_enable | output | 8 | Interrupt-enable register |

## Verification
Every read path of this block is combinational, so the bench applies each address on a falling edge and compares `cpu_rdata` and the outward address ports one nanosecond later, in the same cycle. Write strobes toward the external memories and the mapper are also combinational and are sampled in that same window while `cpu_we` is high. Internal state (bank register, sprite RAM, high RAM, clock registers, interrupt enable, sticky flags) changes on the single rising edge that sees the write, so the bench releases the strobe right after that edge and reads the result back on the next falling edge; one check deliberately reads the target before that edge to confirm the old value is still returned.

// File: rtl/mmap_pkg.sv
`timescale 1ns/1ps
package mmap_pkg;

   typedef enum logic [3:0] {
      RG_ROM_FIX,
      RG_ROM_SW,
      RG_VRAM,
      RG_EXT,
      RG_WRAM_LO,
      RG_WRAM_HI,
      RG_OAM,
      RG_HOLE,
      RG_IO,
      RG_HRAM,
      RG_IE
   } region_e;

   localparam logic [7:0] OPEN_BUS = 8'hFF;

   // Size of the internal byte stores
   localparam int OAM_BYTES  = 160;
   localparam int HRAM_BYTES = 127;

endpackage

// File: rtl/mmap_region_decode.sv
`timescale 1ns/1ps
module mmap_region_decode
   import mmap_pkg::*;
(
   input  logic [15:0] addr,
   output region_e     region
);

   always_comb begin
      unique case (addr[15:12])
         4'h0, 4'h1, 4'h2, 4'h3: region = RG_ROM_FIX;
         4'h4, 4'h5, 4'h6, 4'h7: region = RG_ROM_SW;
         4'h8, 4'h9:             region = RG_VRAM;
         4'hA, 4'hB:             region = RG_EXT;
         4'hC, 4'hE:             region = RG_WRAM_LO;
         4'hD:                   region = RG_WRAM_HI;
         default: begin
            if (addr[11:9] != 3'b111) begin
               region = RG_WRAM_HI;          // upper mirror up to sprite RAM
            end else if (!addr[8]) begin
               region = (addr[7:0] < 8'hA0) ? RG_OAM : RG_HOLE;
            end else if (!addr[7]) begin
               region = RG_IO;
            end else begin
               region = (addr[6:0] == 7'h7F) ? RG_IE : RG_HRAM;
            end
         end
      endcase
   end

endmodule

// File: rtl/mmap_wram_bank.sv
`timescale 1ns/1ps
module mmap_wram_bank #(
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BANK_W-1:0] wbits,
   output logic [BANK_W-1:0] raw,
   output logic [BANK_W-1:0] eff
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw <= '0;
      end else if (we) begin
         raw <= wbits;
      end
   end

   // A stored zero still selects the first switchable bank
   assign eff = (raw == '0) ? BANK_W'(1) : raw;

endmodule

// File: rtl/mmap_byte_file.sv
`timescale 1ns/1ps
module mmap_byte_file #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter bit CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [7:0]       wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [7:0]       rdata
);

   if (DEPTH < 1 || DEPTH > (1 << IDX_W)) begin : g_bad_depth
      $error("mmap_byte_file: DEPTH does not fit IDX_W");
   end

   logic [7:0] mem [DEPTH];
   logic       w_ok;

   assign w_ok = we && (int'(widx) < DEPTH);

   if (CLEAR) begin : g_cleared
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (w_ok) begin
            mem[widx] <= wdata;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (w_ok) mem[widx] <= wdata;
      end
   end

   assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : mmap_pkg::OPEN_BUS;

endmodule

// File: rtl/banked_mem_decoder.sv
`timescale 1ns/1ps
module banked_mem_decoder
   import mmap_pkg::*;
#(
   parameter int             ROM_BANK_W    = 8,
   parameter int             WRAM_BANK_W   = 3,
   parameter int             CLK_REG_COUNT = 5,
   parameter int             CLK_IDX_W     = 3,
   parameter logic [6:0]     BANK_REG_OFS  = 7'h70,
   localparam int            ROM_AW        = ROM_BANK_W + 14,
   localparam int            WRAM_AW       = WRAM_BANK_W + 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           cpu_addr,
   input  logic                  cpu_we,
   input  logic [7:0]            cpu_wdata,
   output logic [7:0]            cpu_rdata,
   input  logic [1:0]            video_mode,
   input  logic                  clk_regs_on,
   input  logic                  sram_on,
   input  logic [CLK_IDX_W-1:0]  clk_reg_idx,
   input  logic [ROM_BANK_W-1:0] rom_bank_sel,
   output logic [ROM_AW-1:0]     rom_addr,
   input  logic [7:0]            rom_rdata,
   output logic                  mapper_we,
   output logic [14:0]           mapper_addr,
   output logic [12:0]           vram_addr,
   output logic                  vram_we,
   input  logic [7:0]            vram_rdata,
   output logic [12:0]           sram_addr,
   output logic                  sram_we,
   input  logic [7:0]            sram_rdata,
   output logic [WRAM_AW-1:0]    wram_addr,
   output logic                  wram_we,
   input  logic [7:0]            wram_rdata,
   output logic [6:0]            io_addr,
   output logic                  io_we,
   input  logic [7:0]            io_rdata,
   output logic [7:0]            mem_wdata,
   output logic                  sram_dirty,
   output logic                  hole_err,
   output logic [7:0]            irq_enable
);

   // Elaboration-time parameter checks
   if (ROM_BANK_W < 1 || ROM_BANK_W > 12) begin : g_bad_rom
      $error("banked_mem_decoder: ROM_BANK_W out of range");
   end
   if (WRAM_BANK_W < 1 || WRAM_BANK_W > 7) begin : g_bad_wram
      $error("banked_mem_decoder: WRAM_BANK_W out of range");
   end
   if (CLK_REG_COUNT < 1 || CLK_REG_COUNT > (1 << CLK_IDX_W)) begin : g_bad_clk
      $error("banked_mem_decoder: CLK_REG_COUNT does not fit CLK_IDX_W");
   end

   localparam int FILL_W = 8 - WRAM_BANK_W;

   region_e                region;
   logic [WRAM_BANK_W-1:0] bank_raw;
   logic [WRAM_BANK_W-1:0] bank_eff;
   logic                   bank_hit;
   logic                   bank_wr;
   logic                   oam_open;
   logic                   oam_wr;
   logic                   hram_wr;
   logic                   clk_wr;
   logic                   ext_hit;
   logic [7:0]             oam_rd;
   logic [7:0]             hram_rd;
   logic [7:0]             clk_rd;
   logic [7:0]             ie_q;
   logic                   dirty_q;
   logic                   hole_q;

   mmap_region_decode u_decode (
      .addr   (cpu_addr),
      .region (region)
   );

   // ---------------- work-RAM bank register ----------------
   assign bank_hit = (region == RG_IO) && (cpu_addr[6:0] == BANK_REG_OFS);
   assign bank_wr  = cpu_we && bank_hit;

   mmap_wram_bank #(.BANK_W(WRAM_BANK_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_wr),
      .wbits (cpu_wdata[WRAM_BANK_W-1:0]),
      .raw   (bank_raw),
      .eff   (bank_eff)
   );

   // ---------------- internal byte stores ----------------
   assign oam_open = ~video_mode[1];
   assign oam_wr   = cpu_we && (region == RG_OAM) && oam_open;
   assign hram_wr  = cpu_we && (region == RG_HRAM);
   assign ext_hit  = (region == RG_EXT);
   assign clk_wr   = cpu_we && ext_hit && clk_regs_on;

   mmap_byte_file #(.DEPTH(OAM_BYTES), .IDX_W(8), .CLEAR(1'b0)) u_oam (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (oam_wr),
      .widx  (cpu_addr[7:0]),
      .wdata (cpu_wdata),
      .ridx  (cpu_addr[7:0]),
      .rdata (oam_rd)
   );

   mmap_byte_file #(.DEPTH(HRAM_BYTES), .IDX_W(7), .CLEAR(1'b1)) u_hram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (hram_wr),
      .widx  (cpu_addr[6:0]),
      .wdata (cpu_wdata),
      .ridx  (cpu_addr[6:0]),
      .rdata (hram_rd)
   );

   mmap_byte_file #(.DEPTH(CLK_REG_COUNT), .IDX_W(CLK_IDX_W), .CLEAR(1'b1)) u_clkregs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (clk_wr),
      .widx  (clk_reg_idx),
      .wdata (cpu_wdata),
      .ridx  (clk_reg_idx),
      .rdata (clk_rd)
   );

   // ---------------- interrupt enable and sticky flags ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q    <= '0;
         dirty_q <= 1'b0;
         hole_q  <= 1'b0;
      end else begin
         if (cpu_we && (region == RG_IE)) ie_q <= cpu_wdata;
         if (cpu_we && ext_hit)           dirty_q <= 1'b1;
         if (cpu_we && (region == RG_HOLE)) hole_q <= 1'b1;
      end
   end

   assign irq_enable = ie_q;
   assign sram_dirty = dirty_q;
   assign hole_err   = hole_q;

   // ---------------- outward addresses and strobes ----------------
   assign rom_addr    = (region == RG_ROM_SW) ? {rom_bank_sel, cpu_addr[13:0]}
                                              : {{ROM_BANK_W{1'b0}}, cpu_addr[13:0]};
   assign mapper_addr = cpu_addr[14:0];
   assign mapper_we   = cpu_we && ((region == RG_ROM_FIX) || (region == RG_ROM_SW));

   assign vram_addr   = cpu_addr[12:0];
   assign vram_we     = cpu_we && (region == RG_VRAM);

   assign sram_addr   = cpu_addr[12:0];
   assign sram_we     = cpu_we && ext_hit && !clk_regs_on && sram_on;

   assign wram_addr   = (region == RG_WRAM_HI) ? {bank_eff, cpu_addr[11:0]}
                                               : {{WRAM_BANK_W{1'b0}}, cpu_addr[11:0]};
   assign wram_we     = cpu_we && ((region == RG_WRAM_LO) || (region == RG_WRAM_HI));

   assign io_addr     = cpu_addr[6:0];
   assign io_we       = cpu_we && (region == RG_IO) && !bank_hit;

   assign mem_wdata   = cpu_wdata;

   // ---------------- read steering ----------------
   always_comb begin
      cpu_rdata = OPEN_BUS;
      unique case (region)
         RG_ROM_FIX, RG_ROM_SW:   cpu_rdata = rom_rdata;
         RG_VRAM:                 cpu_rdata = vram_rdata;
         RG_EXT: begin
            if (clk_regs_on)      cpu_rdata = clk_rd;
            else if (sram_on)     cpu_rdata = sram_rdata;
            else                  cpu_rdata = OPEN_BUS;
         end
         RG_WRAM_LO, RG_WRAM_HI:  cpu_rdata = wram_rdata;
         RG_OAM:                  cpu_rdata = oam_open ? oam_rd : OPEN_BUS;
         RG_HOLE:                 cpu_rdata = OPEN_BUS;
         RG_IO:                   cpu_rdata = bank_hit ? {{FILL_W{1'b1}}, bank_raw} : io_rdata;
         RG_HRAM:                 cpu_rdata = hram_rd;
         RG_IE:                   cpu_rdata = ie_q;
         default:                 cpu_rdata = OPEN_BUS;
      endcase
   end

endmodule

// File: rtl/banked_mem_decoder_checker.sv
`timescale 1ns/1ps
module banked_mem_decoder_checker #(
   parameter int WRAM_AW = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic [15:0]        cpu_addr,
   input logic               cpu_we,
   input logic [7:0]         cpu_wdata,
   input logic [7:0]         cpu_rdata,
   input logic [1:0]         video_mode,
   input logic               clk_regs_on,
   input logic               sram_on,
   input logic               mapper_we,
   input logic               vram_we,
   input logic               sram_we,
   input logic               wram_we,
   input logic               io_we,
   input logic [WRAM_AW-1:0] wram_addr,
   input logic               sram_dirty,
   input logic               hole_err,
   input logic [7:0]         irq_enable
);

   logic in_oam, in_hole, in_ext;
   assign in_oam  = (cpu_addr >= 16'hFE00) && (cpu_addr < 16'hFEA0);
   assign in_hole = (cpu_addr >= 16'hFEA0) && (cpu_addr < 16'hFF00);
   assign in_ext  = (cpu_addr[15:13] == 3'b101);

   p_rom_write_to_mapper_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && !cpu_addr[15]) |-> (mapper_we && !vram_we && !sram_we && !wram_we && !io_we));

   p_switch_bank_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:12] == 4'hD) |-> (wram_addr[WRAM_AW-1:12] != '0));

   p_sprite_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_oam && video_mode[1]) |-> (cpu_rdata == 8'hFF));

   p_hole_write_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && in_hole) |=> hole_err);

   p_hole_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && in_hole) |-> !(mapper_we || vram_we || sram_we || wram_we || io_we));

   p_ext_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ext && !clk_regs_on && !sram_on) |-> (cpu_rdata == 8'hFF && !sram_we));

   p_dirty_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dirty |=> sram_dirty);

   p_ie_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr == 16'hFFFF) |=> (irq_enable == $past(cpu_wdata)));

endmodule

bind banked_mem_decoder banked_mem_decoder_checker #(.WRAM_AW(WRAM_AW)) u_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_addr    (cpu_addr),
   .cpu_we      (cpu_we),
   .cpu_wdata   (cpu_wdata),
   .cpu_rdata   (cpu_rdata),
   .video_mode  (video_mode),
   .clk_regs_on (clk_regs_on),
   .sram_on     (sram_on),
   .mapper_we   (mapper_we),
   .vram_we     (vram_we),
   .sram_we     (sram_we),
   .wram_we     (wram_we),
   .io_we       (io_we),
   .wram_addr   (wram_addr),
   .sram_dirty  (sram_dirty),
   .hole_err    (hole_err),
   .irq_enable  (irq_enable)
);

// File: tb/banked_mem_decoder_tb_top.sv
`timescale 1ns/1ps
module banked_mem_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_we = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic [1:0]  video_mode = 2'd0;
   logic        clk_regs_on = 1'b0;
   logic        sram_on = 1'b0;
   logic [2:0]  clk_reg_idx = '0;
   logic [7:0]  rom_bank_sel = 8'd1;
   logic [21:0] rom_addr;
   logic [7:0]  rom_rdata;
   logic        mapper_we;
   logic [14:0] mapper_addr;
   logic [12:0] vram_addr;
   logic        vram_we;
   logic [12:0] sram_addr;
   logic        sram_we;
   logic [14:0] wram_addr;
   logic        wram_we;
   logic [6:0]  io_addr;
   logic        io_we;
   logic [7:0]  mem_wdata;
   logic        sram_dirty;
   logic        hole_err;
   logic [7:0]  irq_enable;

   // Simple memory models: each target answers with its own marker
   assign rom_rdata = rom_addr[7:0] ^ rom_addr[21:14];
   localparam logic [7:0] VRAM_MARK = 8'h5A;
   localparam logic [7:0] SRAM_MARK = 8'h3C;
   localparam logic [7:0] WRAM_MARK = 8'hC3;
   localparam logic [7:0] IO_MARK   = 8'h96;

   always #2 clk = ~clk;   // 250 MHz

   banked_mem_decoder dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .video_mode(video_mode), .clk_regs_on(clk_regs_on), .sram_on(sram_on),
      .clk_reg_idx(clk_reg_idx), .rom_bank_sel(rom_bank_sel),
      .rom_addr(rom_addr), .rom_rdata(rom_rdata),
      .mapper_we(mapper_we), .mapper_addr(mapper_addr),
      .vram_addr(vram_addr), .vram_we(vram_we), .vram_rdata(VRAM_MARK),
      .sram_addr(sram_addr), .sram_we(sram_we), .sram_rdata(SRAM_MARK),
      .wram_addr(wram_addr), .wram_we(wram_we), .wram_rdata(WRAM_MARK),
      .io_addr(io_addr), .io_we(io_we), .io_rdata(IO_MARK),
      .mem_wdata(mem_wdata), .sram_dirty(sram_dirty), .hole_err(hole_err),
      .irq_enable(irq_enable)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Present an address for a read; results are sampled 1 ns later
   task automatic put_addr(input logic [15:0] a);
      @(negedge clk);
      cpu_we   = 1'b0;
      cpu_addr = a;
      #1;
   endtask

   // Hold a write across one rising edge, then release it
   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr  = a;
      cpu_wdata = d;
      cpu_we    = 1'b1;
      @(posedge clk);
      #1;
      cpu_we = 1'b0;
   endtask

   task automatic t_reset;
      chk("R12 ie after reset", irq_enable, 8'h00);
      chk("R10 dirty after reset", sram_dirty, 1'b0);
      chk("R8 hole flag after reset", hole_err, 1'b0);
      put_addr(16'hFF70);
      chk("R5 bank reg reset readback", cpu_rdata, 8'hF8);
      put_addr(16'hD123);
      chk("R5 reset bank is 1", wram_addr, 15'h1123);
   endtask

   task automatic t_rom;
      rom_bank_sel = 8'h05;
      put_addr(16'h1234);
      chk("R1 fixed rom addr", rom_addr, 22'h001234);
      chk("R1 fixed rom data", cpu_rdata, 8'h34);
      put_addr(16'h5678);
      chk("R1 switch rom addr", rom_addr, {8'h05, 14'h1678});
      chk("R1 switch rom data", cpu_rdata, 8'h78 ^ 8'h05);
   endtask

   task automatic t_mapper;
      @(negedge clk);
      cpu_addr = 16'h2100; cpu_wdata = 8'h07; cpu_we = 1'b1;
      #1;
      chk("R2 mapper strobe", mapper_we, 1'b1);
      chk("R2 mapper addr", mapper_addr, 15'h2100);
      chk("R2 mapper data", mem_wdata, 8'h07);
      chk("R2 no memory strobe", {vram_we, sram_we, wram_we, io_we}, 4'b0000);
      cpu_addr = 16'h7FFF;
      #1;
      chk("R2 mapper addr top", mapper_addr, 15'h7FFF);
      @(posedge clk); #1; cpu_we = 1'b0;
   endtask

   task automatic t_vram;
      put_addr(16'h9ABC);
      chk("R3 vram addr", vram_addr, 13'h1ABC);
      chk("R3 vram data", cpu_rdata, VRAM_MARK);
      @(negedge clk); cpu_we = 1'b1; #1;
      chk("R3 vram strobe", vram_we, 1'b1);
      @(posedge clk); #1; cpu_we = 1'b0;
   endtask

   task automatic t_wram_bank;
      put_addr(16'hC456);
      chk("R4 fixed wram addr", wram_addr, 15'h0456);
      chk("R4 wram data", cpu_rdata, WRAM_MARK);
      do_write(16'hFF70, 8'h03);
      put_addr(16'hD456);
      chk("R4 bank3 addr", wram_addr, 15'h3456);
      do_write(16'hFF70, 8'hFA);            // low bits 010
      put_addr(16'hD456);
      chk("R5 only low 3 bits kept", wram_addr, 15'h2456);
      put_addr(16'hFF70);
      chk("R5 readback bank 2", cpu_rdata, 8'hFA);
      do_write(16'hFF70, 8'h08);            // low bits 000
      put_addr(16'hDFFF);
      chk("R5 zero selects bank 1", wram_addr, 15'h1FFF);
      do_write(16'hFF70, 8'h07);
      put_addr(16'hD000);
      chk("R4 top bank", wram_addr, 15'h7000);
   endtask

   task automatic t_echo;
      do_write(16'hFF70, 8'h02);
      put_addr(16'hE456);
      chk("R6 low mirror", wram_addr, 15'h0456);
      put_addr(16'hF456);
      chk("R6 high mirror", wram_addr, 15'h2456);
      put_addr(16'hFDFF);
      chk("R6 high mirror end", wram_addr, 15'h2DFF);
      chk("R6 mirror data", cpu_rdata, WRAM_MARK);
   endtask

   task automatic t_sprite;
      video_mode = 2'd0;
      do_write(16'hFE10, 8'h77);
      do_write(16'hFE9F, 8'h9F);
      put_addr(16'hFE10);
      chk("R7 mode0 read", cpu_rdata, 8'h77);
      video_mode = 2'd3;
      put_addr(16'hFE10);
      chk("R7 mode3 read closed", cpu_rdata, 8'hFF);
      video_mode = 2'd2;
      do_write(16'hFE10, 8'h11);
      video_mode = 2'd1;
      put_addr(16'hFE10);
      chk("R7 mode2 write dropped", cpu_rdata, 8'h77);
      put_addr(16'hFE9F);
      chk("R7 last sprite byte", cpu_rdata, 8'h9F);
      video_mode = 2'd0;
   endtask

   task automatic t_hole;
      put_addr(16'hFEA0);
      chk("R8 hole read", cpu_rdata, 8'hFF);
      chk("R8 flag clear before write", hole_err, 1'b0);
      @(negedge clk);
      cpu_addr = 16'hFEC0; cpu_wdata = 8'h55; cpu_we = 1'b1;
      #1;
      chk("R8 hole write strobes", {mapper_we, vram_we, sram_we, wram_we, io_we}, 5'b0);
      @(posedge clk); #1; cpu_we = 1'b0;
      put_addr(16'hFEFF);
      chk("R8 hole flag set", hole_err, 1'b1);
      chk("R8 hole read end", cpu_rdata, 8'hFF);
   endtask

   task automatic t_ext;
      clk_regs_on = 1'b0; sram_on = 1'b0;
      put_addr(16'hA000);
      chk("R9 window closed", cpu_rdata, 8'hFF);
      chk("R10 no dirty on read", sram_dirty, 1'b0);
      sram_on = 1'b1;
      put_addr(16'hBFFF);
      chk("R9 sram addr", sram_addr, 13'h1FFF);
      chk("R9 sram data", cpu_rdata, SRAM_MARK);
      clk_regs_on = 1'b1; clk_reg_idx = 3'd2;
      @(negedge clk);
      cpu_addr = 16'hB000; cpu_wdata = 8'h42; cpu_we = 1'b1;
      #1;
      chk("R9 clock regs win over sram", sram_we, 1'b0);
      @(posedge clk); #1; cpu_we = 1'b0;
      put_addr(16'hA123);
      chk("R9 clock reg readback", cpu_rdata, 8'h42);
      chk("R10 dirty set", sram_dirty, 1'b1);
      clk_reg_idx = 3'd6;
      put_addr(16'hA123);
      chk("R9 clock index beyond count", cpu_rdata, 8'hFF);
      clk_regs_on = 1'b0;
      put_addr(16'hA000);
      chk("R10 dirty stays", sram_dirty, 1'b1);
      sram_on = 1'b0;
   endtask

   task automatic t_io_hram;
      put_addr(16'hFF05);
      chk("R11 io addr", io_addr, 7'h05);
      chk("R11 io data", cpu_rdata, IO_MARK);
      put_addr(16'hFFFE);
      chk("R11 hram cleared", cpu_rdata, 8'h00);
      do_write(16'hFF81, 8'h5E);
      put_addr(16'hFF81);
      chk("R11 hram readback", cpu_rdata, 8'h5E);
      // R13: before the edge the old value is still read
      @(negedge clk);
      cpu_addr = 16'hFF82; cpu_wdata = 8'hAB; cpu_we = 1'b1;
      #1;
      chk("R13 old value before edge", cpu_rdata, 8'h00);
      @(posedge clk); #1; cpu_we = 1'b0;
      put_addr(16'hFF82);
      chk("R13 new value after edge", cpu_rdata, 8'hAB);
   endtask

   task automatic t_ie;
      do_write(16'hFFFF, 8'h1F);
      chk("R12 irq enable port", irq_enable, 8'h1F);
      put_addr(16'hFFFF);
      chk("R12 ie readback", cpu_rdata, 8'h1F);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_rom();
      t_mapper();
      t_vram();
      t_wram_bank();
      t_echo();
      t_sprite();
      t_hole();
      t_ext();
      t_io_hram();
      t_ie();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule